// File: doc/BRIEF.md
# Stopwatch Timing Core

This block measures elapsed time on a fixed 5 kHz clock and holds the result as six BCD digits. It covers minutes, seconds, tenths and hundredths of a second, from 00:00.00 up to 59:59.99. An internal divider turns the slow clock into a one-cycle tick every 10 ms. On each tick, while the watch is running, the digit chain advances by one hundredth. Carries ripple through the chain within the same clock cycle. The two tens digits for seconds and minutes roll over at six, and all the other digits roll over at ten.

A single clean, synchronous button controls the watch. The first press starts timing and the next press stops it. Each press counts once however long the button is held, because the controller moves one step on the press and one step on the release. A reset input can be applied at any moment, even mid-count. It clears every digit and the controller at once, so the next run begins at zero. Display scanning, segment decoding and debouncing are left to surrounding logic.

Top module: `stopwatch_core`

## Requirements
- R1: While `rst` is high, all six digits read 0 and `running` reads 0, whether or not the watch was counting; after release the watch stays halted at 00:00.00 until a press.
- R2: A press (`btn` sampled high at a clock edge after being low at the previous edge) toggles `running`; the new value appears right after that edge, so the first press starts and the next press stops.
- R3: Holding `btn` high over many edges toggles `running` only once; the controller moves on to its settled state only after `btn` is seen low.
- R4: The divider is free-running from reset and produces one tick every `TICK_DIV` clocks (default 50, which is 10 ms at 5 kHz). While running, `hundredths` advances only on those edges.
- R5: `sec_tens` and `min_tens` count 0..5 and the other four digits count 0..9. A digit at its maximum returns to 0 when it advances, so 59.99 s is followed by 1:00.00 and 59:59.99 is followed by 00:00.00.
- R6: A digit advances on a tick while running only when every lower digit is at its maximum, and the whole ripple settles in that single edge.
- R7: While `running` is 0, all six digits keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 5 kHz timing clock |
| rst | input | 1 | Asynchronous active-high clear of all state |
| btn | input | 1 | Clean start/stop button, high while pressed |
| running | output | 1 | High while the watch is counting |
| min_tens | output | DIGIT_W | Minute tens digit, 0..5 |
| min_units | output | DIGIT_W | Minute units digit, 0..9 |
| sec_tens | output | DIGIT_W | Second tens digit, 0..5 |
| sec_units | output | DIGIT_W | Second units digit, 0..9 |
| tenths | output | DIGIT_W | Tenths of a second, 0..9 |
| hundredths | output | DIGIT_W | Hundredths of a second, 0..9 |

## Verification
A divider phase error is invisible until a few ticks have gone by, and then `hundredths` slowly drifts away from the clock count. For that reason the bench compares against a time model that counts every edge from reset. A bad carry or a wrong modulus shows up at the first rollover of the affected digit, as an out-of-range digit or a missing increment. The bench therefore samples on both sides of the 9→10, 99→100, 999→1000 and 5999→6000 hundredths boundaries. A controller stuck in its pressed state shows up as `running` flipping during a long hold or failing to return after release. Those windows are checked while the button is held down and just after it is released.

// File: rtl/sw_pkg.sv
package sw_pkg;

   localparam int NUM_DIGITS   = 6;
   localparam int IDX_HUND     = 0;
   localparam int IDX_TENTHS   = 1;
   localparam int IDX_SEC_UNIT = 2;
   localparam int IDX_SEC_TENS = 3;
   localparam int IDX_MIN_UNIT = 4;
   localparam int IDX_MIN_TENS = 5;

   // press/release controller: bit 0 = counting enabled
   typedef enum logic [1:0] {
      ST_HALTED   = 2'b00,
      ST_GO_HELD  = 2'b01,
      ST_COUNTING = 2'b11,
      ST_STOP_HELD = 2'b10
   } sw_state_e;

   function automatic int digit_modulus(input int idx);
      return (idx == IDX_SEC_TENS || idx == IDX_MIN_TENS) ? 6 : 10;
   endfunction

endpackage

// File: rtl/sw_tick_div.sv
module sw_tick_div #(
   parameter int TICK_DIV = 50
) (
   input  logic clk,
   input  logic rst,
   output logic tick
);
   localparam int CW = (TICK_DIV > 2) ? $clog2(TICK_DIV) : 1;
   localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);

   logic [CW-1:0] phase_q;

   assign tick = (phase_q == LAST);

   always_ff @(posedge clk or posedge rst) begin
      if (rst)       phase_q <= '0;
      else if (tick) phase_q <= '0;
      else           phase_q <= phase_q + CW'(1);
   end
endmodule

// File: rtl/sw_toggle_ctrl.sv
module sw_toggle_ctrl
   import sw_pkg::*;
(
   input  logic clk,
   input  logic rst,
   input  logic btn,
   output logic run
);
   sw_state_e state_q, state_d;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_HALTED:    if (btn)  state_d = ST_GO_HELD;
         ST_GO_HELD:   if (!btn) state_d = ST_COUNTING;
         ST_COUNTING:  if (btn)  state_d = ST_STOP_HELD;
         ST_STOP_HELD: if (!btn) state_d = ST_HALTED;
         default:                state_d = ST_HALTED;
      endcase
   end

   always_ff @(posedge clk or posedge rst) begin
      if (rst) state_q <= ST_HALTED;
      else     state_q <= state_d;
   end

   assign run = state_q[0];
endmodule

// File: rtl/sw_digit.sv
module sw_digit #(
   parameter int W   = 4,
   parameter int MOD = 10
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         inc,
   output logic [W-1:0] value,
   output logic         at_max
);
   localparam logic [W-1:0] TOP = W'(MOD - 1);

   generate
      if (MOD < 2 || MOD > (1 << W)) begin : g_bad_mod
         $error("sw_digit: MOD does not fit W bits");
      end
   endgenerate

   assign at_max = (value == TOP);

   always_ff @(posedge clk or posedge rst) begin
      if (rst)         value <= '0;
      else if (inc)    value <= at_max ? '0 : value + W'(1);
   end
endmodule

// File: rtl/stopwatch_core.sv
module stopwatch_core
   import sw_pkg::*;
#(
   parameter int TICK_DIV = 50,
   parameter int DIGIT_W  = 4
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               btn,
   output logic               running,
   output logic [DIGIT_W-1:0] min_tens,
   output logic [DIGIT_W-1:0] min_units,
   output logic [DIGIT_W-1:0] sec_tens,
   output logic [DIGIT_W-1:0] sec_units,
   output logic [DIGIT_W-1:0] tenths,
   output logic [DIGIT_W-1:0] hundredths
);
   localparam int ND = NUM_DIGITS;

   generate
      if (TICK_DIV < 2) begin : g_bad_div
         $error("stopwatch_core: TICK_DIV must be at least 2");
      end
      if (DIGIT_W < 4) begin : g_bad_w
         $error("stopwatch_core: DIGIT_W must hold a BCD digit");
      end
   endgenerate

   logic               tick_w;
   logic [DIGIT_W-1:0] digit_q [ND];
   logic [ND-1:0]      at_max;
   logic [ND:0]        carry;

   sw_tick_div #(.TICK_DIV(TICK_DIV)) i_div (
      .clk  (clk),
      .rst  (rst),
      .tick (tick_w)
   );

   sw_toggle_ctrl i_ctrl (
      .clk (clk),
      .rst (rst),
      .btn (btn),
      .run (running)
   );

   assign carry[0] = tick_w & running;

   generate
      for (genvar g = 0; g < ND; g++) begin : g_digit
         localparam int MOD = digit_modulus(g);
         sw_digit #(.W(DIGIT_W), .MOD(MOD)) i_dig (
            .clk    (clk),
            .rst    (rst),
            .inc    (carry[g]),
            .value  (digit_q[g]),
            .at_max (at_max[g])
         );
         assign carry[g+1] = carry[g] & at_max[g];
      end
   endgenerate

   assign hundredths = digit_q[IDX_HUND];
   assign tenths     = digit_q[IDX_TENTHS];
   assign sec_units  = digit_q[IDX_SEC_UNIT];
   assign sec_tens   = digit_q[IDX_SEC_TENS];
   assign min_units  = digit_q[IDX_MIN_UNIT];
   assign min_tens   = digit_q[IDX_MIN_TENS];
endmodule

// File: rtl/sw_core_chk.sv
module sw_core_chk #(
   parameter int DIGIT_W = 4
) (
   input logic               clk,
   input logic               rst,
   input logic               btn,
   input logic               running,
   input logic               tick,
   input logic               wrap,
   input logic [DIGIT_W-1:0] min_tens,
   input logic [DIGIT_W-1:0] min_units,
   input logic [DIGIT_W-1:0] sec_tens,
   input logic [DIGIT_W-1:0] sec_units,
   input logic [DIGIT_W-1:0] tenths,
   input logic [DIGIT_W-1:0] hundredths
);
   logic btn_prev;
   always_ff @(posedge clk or posedge rst) begin
      if (rst) btn_prev <= 1'b0;
      else     btn_prev <= btn;
   end

   wire [6*DIGIT_W-1:0] all_dig = {min_tens, min_units, sec_tens, sec_units, tenths, hundredths};

   p_reset_clear_r1: assert property (@(posedge clk)
      (rst && $past(rst)) |-> (all_dig == '0 && !running));

   p_start_r2: assert property (@(posedge clk) disable iff (rst)
      (btn && !btn_prev && !running) |=> running);

   p_stop_r2: assert property (@(posedge clk) disable iff (rst)
      (btn && !btn_prev && running) |=> !running);

   p_hold_once_r3: assert property (@(posedge clk) disable iff (rst)
      (btn && btn_prev) |=> $stable(running));

   p_tick_gap_r4: assert property (@(posedge clk) disable iff (rst)
      tick |=> !tick);

   p_hund_step_r4: assert property (@(posedge clk) disable iff (rst)
      (!tick) |=> $stable(hundredths));

   p_range_r5: assert property (@(posedge clk) disable iff (rst)
      (hundredths <= 9 && tenths <= 9 && sec_units <= 9 &&
       sec_tens <= 5 && min_units <= 9 && min_tens <= 5));

   p_full_wrap_r5: assert property (@(posedge clk) disable iff (rst)
      wrap |=> (all_dig == '0));

   p_tenths_carry_r6: assert property (@(posedge clk) disable iff (rst)
      (running && tick && hundredths == 9 && tenths != 9)
      |=> (tenths == $past(tenths) + DIGIT_W'(1) && hundredths == '0));

   p_stopped_hold_r7: assert property (@(posedge clk) disable iff (rst)
      (!running) |=> $stable(all_dig));
endmodule

bind stopwatch_core sw_core_chk #(.DIGIT_W(DIGIT_W)) i_chk (
   .clk        (clk),
   .rst        (rst),
   .btn        (btn),
   .running    (running),
   .tick       (tick_w),
   .wrap       (carry[NUM_DIGITS]),
   .min_tens   (min_tens),
   .min_units  (min_units),
   .sec_tens   (sec_tens),
   .sec_units  (sec_units),
   .tenths     (tenths),
   .hundredths (hundredths)
);

// File: tb/test_stopwatch_core.sv
module test_stopwatch_core;
   localparam int DIV = 2;
   localparam int W   = 4;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic btn = 1'b0;
   logic running;
   logic [W-1:0] min_tens, min_units, sec_tens, sec_units, tenths, hundredths;

   always #5 clk = ~clk;

   stopwatch_core #(.TICK_DIV(DIV), .DIGIT_W(W)) i_stopwatch_core (
      .clk(clk), .rst(rst), .btn(btn), .running(running),
      .min_tens(min_tens), .min_units(min_units), .sec_tens(sec_tens),
      .sec_units(sec_units), .tenths(tenths), .hundredths(hundredths)
   );

   // reference time model built from the requirements
   int   m_div, m_cs;
   logic m_run, m_btn_prev;
   always @(posedge clk or posedge rst) begin
      if (rst) begin
         m_div = 0; m_cs = 0; m_run = 1'b0; m_btn_prev = 1'b0;
      end else begin
         if (m_div == DIV - 1) begin
            m_div = 0;
            if (m_run) m_cs = (m_cs + 1) % 360000;
         end else begin
            m_div = m_div + 1;
         end
         if (btn && !m_btn_prev) m_run = !m_run;
         m_btn_prev = btn;
      end
   end

   typedef struct { string tag; logic [24:0] val; } exp_t;
   exp_t sb_q[$];
   int checks = 0, failures = 0;
   bit done = 0;

   function automatic logic [24:0] model_word(int cs, logic run);
      return {4'(cs / 60000 % 6), 4'(cs / 6000 % 10), 4'(cs / 1000 % 6),
              4'(cs / 100 % 10), 4'(cs / 10 % 10), 4'(cs % 10), run};
   endfunction

   task automatic expect_now(input string tag);
      exp_t e;
      @(negedge clk); #1;
      e.tag = tag;
      e.val = model_word(m_cs, m_run);
      sb_q.push_back(e);
      #1;
   endtask

   // monitor: pops expected items and compares with the ports
   initial begin
      forever begin
         exp_t e;
         logic [24:0] act;
         wait (sb_q.size() != 0);
         e = sb_q.pop_front();
         act = {min_tens, min_units, sec_tens, sec_units, tenths, hundredths, running};
         checks++;
         if (act !== e.val) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", e.tag, act, e.val);
         end
      end
   end

   task automatic press(input int hold);
      @(negedge clk); btn = 1'b1;
      repeat (hold) @(negedge clk);
      btn = 1'b0;
   endtask

   task automatic run_until(input int cs);
      while (m_cs != cs) @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      expect_now("R1 digits and running zero during reset");
      rst = 1'b0;
      repeat (10) @(negedge clk);
      expect_now("R7 halted after reset, digits unchanged");

      press(1);
      expect_now("R2 first press starts");
      run_until(9);  expect_now("R4 hundredths at 9");
      run_until(10); expect_now("R6 tenths carry at 0.10");
      run_until(99); expect_now("R6 before 1.00");
      run_until(100); expect_now("R6 seconds carry at 1.00");
      run_until(999); expect_now("R5 at 9.99");
      run_until(1000); expect_now("R5 sec_tens carry at 10.00");
      run_until(5999); expect_now("R5 at 59.99");
      run_until(6000); expect_now("R5 sec_tens mod 6 rolls to 1:00.00");

      // long hold: toggles once
      @(negedge clk); btn = 1'b1;
      expect_now("R2 press stops");
      repeat (20) @(negedge clk);
      expect_now("R3 still stopped while held");
      btn = 1'b0;
      expect_now("R3 stopped after release");
      repeat (60) @(negedge clk);
      expect_now("R7 digits held while stopped");

      press(15);
      expect_now("R2 second start resumes");
      run_until(6105); expect_now("R4 resumed counting from held value");

      // reset in the middle of counting
      @(negedge clk); rst = 1'b1; #1;
      expect_now("R1 reset while running clears");
      @(negedge clk); rst = 1'b0;
      repeat (5) @(negedge clk);
      expect_now("R1 halted at zero after reset");
      press(1);
      run_until(3); expect_now("R1 next run starts from zero");

      repeat (4) @(negedge clk);
      wait (sb_q.size() == 0);
      #2;
      if (!done) begin
         done = 1;
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1;
         checks++;
         failures++;
         $display("FAIL watchdog expired actual=hung expected=finished");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule